// File: doc/BRIEF.md
# Structured Timeslot HDLC Bit Gatherer

This block sits between a T1 or E1 TDM port and the HDLC coder of one bundle. Each port byte arrives with its timeslot number, and a static frame-type input says whether the port carries T1 or E1 framing. A 32-bit ownership mask and a coding-width setting decide which bytes, and which bits of those bytes, belong to the bundle. The owned bits leave the block as a serial stream, most significant bit first, one bit per cycle while `bit_valid` is high. The stream is ready for flag and zero-bit handling further on.

Three coding widths are offered: 8 bits per timeslot for Nx64 kb/s channels, 7 bits for 56 kb/s channels and 2 bits for 16 kb/s channels. The 8-bit width may span many timeslots of one port, so six timeslots give a 384 kb/s channel. The narrower widths own exactly one timeslot. An unstructured mode ignores framing, mask and width and serialises every port byte in full. A setup the hardware cannot honour raises `cfg_err` and stops all delivery. Port bytes arrive far slower than the clock: one byte every eight cycles or more.

Top module: `ts_bit_gatherer`

## Requirements
- R1: While reset is asserted and after it is released, with no byte accepted, `bit_valid` is low; a reset during serialisation drops the remaining bits.
- R2: With `cfg_width` = 2'b00 (8-bit), an owned byte appears as all 8 bits, bit 7 first, on 8 consecutive cycles. The first bit is visible in the cycle after the clock edge that samples `in_valid`.
- R3: With `cfg_width` = 2'b01 (7-bit), bits 7 down to 1 of the owned byte are delivered on 7 consecutive cycles, and bit 0 is never delivered.
- R4: With `cfg_width` = 2'b10 (2-bit), two bits are delivered: bits 7,6 when `cfg_pair_lo` = 0, and bits 1,0 when `cfg_pair_lo` = 1, higher bit first.
- R5: In 8-bit mode a byte is owned only when `cfg_mask[in_ts]` is 1. Bytes of several owned timeslots are delivered in arrival order, which is ascending timeslot order within a frame. Bytes of unowned timeslots yield no `bit_valid`.
- R6: Legal timeslots are 1 to 24 when `cfg_e1` = 0 and 1 to 31 when `cfg_e1` = 1; timeslot 0 is never legal.
- R7: In structured mode, `cfg_err` is high in the same cycle when the mask sets an illegal timeslot, or the width code is 2'b11, or more than one mask bit is set at 7-bit or 2-bit width. While `cfg_err` is high, no byte is accepted.
- R8: With `cfg_unstruct` = 1, every byte is delivered as 8 bits MSB first whatever its timeslot, mask or width, and `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A port byte is present this cycle |
| in_byte | input | 8 | Port byte, bit 7 the first bit on the line |
| in_ts | input | 5 | Timeslot number of `in_byte` |
| cfg_e1 | input | 1 | 1 = E1 framing, 0 = T1 framing |
| cfg_unstruct | input | 1 | 1 = pass the whole port stream |
| cfg_width | input | 2 | 00 = 8-bit, 01 = 7-bit, 10 = 2-bit, 11 = invalid |
| cfg_pair_lo | input | 1 | 2-bit mode: 1 = bits 1,0, 0 = bits 7,6 |
| cfg_mask | input | 32 | Bit i set = timeslot i owned by the bundle |
| bit_out | output | 1 | Serial data bit |
| bit_valid | output | 1 | `bit_out` holds a delivered bit |
| cfg_err | output | 1 | Configuration cannot be honoured |

## Verification
`cfg_err` depends only on the configuration inputs, so the bench reads it in the same cycle it changes them. A byte is sampled on one rising edge, and its first bit is due half a cycle later, at the next falling edge. Bit k follows k cycles after that, and `bit_valid` must be low at the falling edge one cycle past the last bit. The bench drives each input at a falling edge and reads every output at the falling edges that follow, counting one edge per stored bit. A byte that must not be delivered is therefore caught by `bit_valid` at the first falling edge after its acceptance edge.

// File: rtl/gath_pkg.sv
package gath_pkg;
  typedef enum logic [1:0] {
    CW_8   = 2'b00,
    CW_7   = 2'b01,
    CW_2   = 2'b10,
    CW_BAD = 2'b11
  } cw_e;

  // Number of bits delivered per owned byte for a coding width.
  function automatic logic [3:0] bits_for(input cw_e w);
    case (w)
      CW_8:    bits_for = 4'd8;
      CW_7:    bits_for = 4'd7;
      CW_2:    bits_for = 4'd2;
      default: bits_for = 4'd0;
    endcase
  endfunction

  // Move the delivered bits to the top of the byte so they leave MSB first.
  function automatic logic [7:0] align_bits(input logic [7:0] b, input cw_e w,
                                            input logic lo);
    if (w == CW_2 && lo) align_bits = {b[1:0], 6'b0};
    else                 align_bits = b;
  endfunction
endpackage

// File: rtl/gath_cfg_check.sv
module gath_cfg_check #(
  parameter int SLOTS   = 32,
  parameter int T1_LAST = 24,
  parameter int E1_LAST = 31
) (
  input  logic [SLOTS-1:0] cfg_mask,
  input  logic             cfg_e1,
  input  logic             cfg_unstruct,
  input  gath_pkg::cw_e    cfg_width,
  output logic [SLOTS-1:0] legal,
  output logic             cfg_err
);
  import gath_pkg::*;

  logic multi;
  logic stray;

  for (genvar i = 0; i < SLOTS; i++) begin : g_legal
    assign legal[i] = (i >= 1) && (i <= (cfg_e1 ? E1_LAST : T1_LAST));
  end

  assign multi   = ($countones(cfg_mask) > 1);
  assign stray   = |(cfg_mask & ~legal);
  assign cfg_err = !cfg_unstruct &&
                   (stray || cfg_width == CW_BAD || (cfg_width != CW_8 && multi));
endmodule

// File: rtl/gath_slot_select.sv
module gath_slot_select #(
  parameter int SLOTS  = 32,
  parameter int BYTE_W = 8,
  localparam int TS_W  = $clog2(SLOTS),
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [SLOTS-1:0]  cfg_mask,
  input  logic [SLOTS-1:0]  legal,
  input  logic              cfg_unstruct,
  input  gath_pkg::cw_e     cfg_width,
  input  logic              cfg_pair_lo,
  input  logic              cfg_err,
  output logic              take,
  output logic [BYTE_W-1:0] take_data,
  output logic [CNT_W-1:0]  take_n
);
  import gath_pkg::*;

  logic owned;

  assign owned = cfg_mask[in_ts] && legal[in_ts] && !cfg_err;
  assign take  = in_valid && (cfg_unstruct || owned);

  always_comb begin
    if (cfg_unstruct) begin
      take_data = in_byte;
      take_n    = CNT_W'(BYTE_W);
    end else begin
      take_data = align_bits(in_byte, cfg_width, cfg_pair_lo);
      take_n    = CNT_W'(bits_for(cfg_width));
    end
  end
endmodule

// File: rtl/gath_shifter.sv
module gath_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic [CNT_W-1:0]  load_n,
  output logic              bit_out,
  output logic              bit_valid
);
  logic [BYTE_W-1:0] sreg;
  logic [CNT_W-1:0]  left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= load_data;
      left <= load_n;
    end else if (left != '0) begin
      sreg <= {sreg[BYTE_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign bit_out   = sreg[BYTE_W-1];
  assign bit_valid = (left != '0);
endmodule

// File: rtl/ts_bit_gatherer.sv
module ts_bit_gatherer #(
  parameter int SLOTS   = 32,
  parameter int T1_LAST = 24,
  parameter int E1_LAST = 31,
  parameter int BYTE_W  = 8,
  localparam int TS_W   = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [TS_W-1:0]   in_ts,
  input  logic              cfg_e1,
  input  logic              cfg_unstruct,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_pair_lo,
  input  logic [SLOTS-1:0]  cfg_mask,
  output logic              bit_out,
  output logic              bit_valid,
  output logic              cfg_err
);
  import gath_pkg::*;

  cw_e              width_e;
  logic [SLOTS-1:0] legal;
  logic             load_evt;
  logic [BYTE_W-1:0] load_data;
  logic [CNT_W-1:0] load_n;

  assign width_e = cw_e'(cfg_width);

  gath_cfg_check #(.SLOTS(SLOTS), .T1_LAST(T1_LAST), .E1_LAST(E1_LAST)) u_cfg (
    .cfg_mask(cfg_mask), .cfg_e1(cfg_e1), .cfg_unstruct(cfg_unstruct),
    .cfg_width(width_e), .legal(legal), .cfg_err(cfg_err)
  );

  gath_slot_select #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_sel (
    .in_valid(in_valid), .in_byte(in_byte), .in_ts(in_ts), .cfg_mask(cfg_mask),
    .legal(legal), .cfg_unstruct(cfg_unstruct), .cfg_width(width_e),
    .cfg_pair_lo(cfg_pair_lo), .cfg_err(cfg_err),
    .take(load_evt), .take_data(load_data), .take_n(load_n)
  );

  gath_shifter #(.BYTE_W(BYTE_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .load_data(load_data),
    .load_n(load_n), .bit_out(bit_out), .bit_valid(bit_valid)
  );
endmodule

// File: rtl/gath_checker.sv
module gath_checker #(
  parameter int SLOTS  = 32,
  parameter int BYTE_W = 8,
  localparam int TS_W  = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_byte,
  input logic [TS_W-1:0]   in_ts,
  input logic [SLOTS-1:0]  cfg_mask,
  input logic              cfg_unstruct,
  input logic [1:0]        cfg_width,
  input logic              cfg_pair_lo,
  input logic              cfg_err,
  input logic              load_evt,
  input logic              bit_out,
  input logic              bit_valid
);
  logic [4:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run <= '0;
    else if (load_evt)           run <= '0;
    else if (bit_valid && run != 5'd31) run <= run + 1'b1;
  end

  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !cfg_unstruct) |-> !load_evt); // R7
  AST_UNOWNED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_unstruct && !cfg_mask[in_ts]) |-> !load_evt); // R5
  AST_FULL_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && (cfg_unstruct || cfg_width == 2'b00)) |=> (bit_valid && bit_out == $past(in_byte[BYTE_W-1]))); // R2
  AST_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !cfg_unstruct && cfg_width == 2'b10 && cfg_pair_lo) |=> (bit_valid && bit_out == $past(in_byte[1]))); // R4
  AST_UNSTRUCT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_unstruct) |-> (load_evt && !cfg_err)); // R8
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 5'(BYTE_W)); // R3
endmodule

bind ts_bit_gatherer gath_checker #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ts(in_ts),
  .cfg_mask(cfg_mask), .cfg_unstruct(cfg_unstruct), .cfg_width(cfg_width),
  .cfg_pair_lo(cfg_pair_lo), .cfg_err(cfg_err), .load_evt(load_evt),
  .bit_out(bit_out), .bit_valid(bit_valid)
);

// File: tb/sim_ts_bit_gatherer.sv
module sim_ts_bit_gatherer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [4:0] in_ts = '0;
  logic cfg_e1 = 1'b0, cfg_unstruct = 1'b0, cfg_pair_lo = 1'b0;
  logic [1:0] cfg_width = 2'b00;
  logic [31:0] cfg_mask = '0;
  logic bit_out, bit_valid, cfg_err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ts_bit_gatherer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ts(in_ts),
    .cfg_e1(cfg_e1), .cfg_unstruct(cfg_unstruct), .cfg_width(cfg_width),
    .cfg_pair_lo(cfg_pair_lo), .cfg_mask(cfg_mask),
    .bit_out(bit_out), .bit_valid(bit_valid), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        unstr;
    logic        e1;
    logic [1:0]  w;
    logic        lo;
    logic [31:0] mask;
    logic [4:0]  ts;
    logic [7:0]  b;
    logic        err;
    logic [3:0]  n;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_0020, 5'd5,  8'hA5, 1'b0, 4'd8, 8'hA5}, // R2
    '{4'd3, 1'b0, 1'b0, 2'b01, 1'b0, 32'h0000_0020, 5'd5,  8'hB3, 1'b0, 4'd7, 8'hB2}, // R3
    '{4'd4, 1'b0, 1'b0, 2'b10, 1'b0, 32'h0000_0020, 5'd5,  8'h43, 1'b0, 4'd2, 8'h40}, // R4 upper
    '{4'd4, 1'b0, 1'b0, 2'b10, 1'b1, 32'h0000_0020, 5'd5,  8'h43, 1'b0, 4'd2, 8'hC0}, // R4 lower
    '{4'd5, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_007E, 5'd3,  8'h3C, 1'b0, 4'd8, 8'h3C}, // R5
    '{4'd5, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_007E, 5'd7,  8'hFF, 1'b0, 4'd0, 8'h00}, // R5 unowned
    '{4'd6, 1'b0, 1'b1, 2'b00, 1'b0, 32'h8000_0000, 5'd31, 8'h5A, 1'b0, 4'd8, 8'h5A}, // R6
    '{4'd6, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0200_0000, 5'd25, 8'hFF, 1'b1, 4'd0, 8'h00}, // R6 T1 ts25
    '{4'd6, 1'b0, 1'b1, 2'b00, 1'b0, 32'h0000_0001, 5'd0,  8'hFF, 1'b1, 4'd0, 8'h00}, // R6 ts0
    '{4'd7, 1'b0, 1'b0, 2'b01, 1'b0, 32'h0000_0006, 5'd1,  8'hFF, 1'b1, 4'd0, 8'h00}, // R7 multi
    '{4'd7, 1'b0, 1'b0, 2'b11, 1'b0, 32'h0000_0020, 5'd5,  8'hFF, 1'b1, 4'd0, 8'h00}, // R7 bad width
    '{4'd8, 1'b1, 1'b0, 2'b01, 1'b0, 32'h0000_0006, 5'd0,  8'hC9, 1'b0, 4'd8, 8'hC9}, // R8
    '{4'd4, 1'b0, 1'b1, 2'b10, 1'b0, 32'h0010_0000, 5'd20, 8'hE1, 1'b0, 4'd2, 8'hC0}  // R4 E1
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [7:0] got = '0;
    bit ok = 1'b1;
    @(negedge clk);
    cfg_unstruct = v.unstr; cfg_e1 = v.e1; cfg_width = v.w;
    cfg_pair_lo = v.lo; cfg_mask = v.mask;
    #1;
    check(cfg_err == v.err, $sformatf("R%0d cfg_err", v.req), 64'(cfg_err), 64'(v.err));
    in_byte = v.b; in_ts = v.ts; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < int'(v.n); i++) begin
      if (!bit_valid) ok = 1'b0;
      got[7-i] = bit_out;
      @(negedge clk);
    end
    if (bit_valid) ok = 1'b0;
    check(ok && got == v.exp, $sformatf("R%0d bits", v.req), 64'(got), 64'(v.exp));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] got, exp;
    int ng, ne;
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1 in reset", 64'(bit_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bit_valid == 1'b0, "R1 after reset", 64'(bit_valid), 64'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R5: one T1 frame, timeslots 0..9, mask owns 1..6, gathered in order
    cfg_unstruct = 1'b0; cfg_e1 = 1'b0; cfg_width = 2'b00; cfg_mask = 32'h0000_007E;
    got = '0; exp = '0; ng = 0; ne = 0;
    for (int s = 0; s < 10; s++) begin
      logic [7:0] b;
      b = 8'(s * 37 + 11);
      if (s >= 1 && s <= 6) begin
        for (int j = 7; j >= 0; j--) begin exp[63-ne] = b[j]; ne++; end
      end
      @(negedge clk);
      in_byte = b; in_ts = 5'(s); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 0; c < 10; c++) begin
        if (bit_valid) begin
          if (ng < 64) got[63-ng] = bit_out;
          ng++;
        end
        @(negedge clk);
      end
    end
    check(ng == 48, "R5 bit count", 64'(ng), 64'd48);
    check(got == exp, "R5 stream", got, exp);

    // R1: reset in the middle of a byte drops the rest
    @(negedge clk);
    in_byte = 8'hFF; in_ts = 5'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_valid == 1'b0, "R1 mid-byte reset", 64'(bit_valid), 64'd0);

    // R7: error config ignores a legal-looking byte (2-bit, two slots)
    cfg_width = 2'b10; cfg_mask = 32'h0000_0003 << 1;
    @(negedge clk);
    in_byte = 8'hC0; in_ts = 5'd1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(bit_valid == 1'b0 && cfg_err == 1'b1, "R7 blocked",
          64'({cfg_err, bit_valid}), 64'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule